// File: doc/BRIEF.md
# Two-Channel Interrupt Request Merger

This block collects the interrupt sources of a pair of serial channels and turns them into one active-high interrupt request line that both channels share. Each channel supplies its transmit-pending and receive-pending flags, its interrupt control byte, its extended control byte and its line status byte. The block qualifies each channel's sources against that channel's enable fields, ORs the two qualified requests, and registers the result.

The block also builds a combined pending-status byte for software. This byte carries the raw transmit and receive pending flags of both channels, and only the channel A register path reads it. The flags of channel B land in channel A's byte rather than in a byte of their own. Both outputs are registered, so a change on any input shows up exactly one clock later. A synchronous active-high reset clears both outputs.

Channel A occupies the low byte of every per-channel bus and the low bit of every per-channel flag pair. Channel B occupies the high byte and the high bit.

Top module: `dual_irq_merge`

## Requirements
- R1: While `rst` is high at a rising clock edge, `irq_o` becomes 0 and `pend_stat_o` becomes 0x00 after that edge, whatever the other inputs are.
- R2: A channel contributes nothing to `irq_o` unless bit 0 (master enable) of its control byte in `wr_cfg_i` is 1. This holds even when all of its sources are pending.
- R3: The transmit source of a channel is active when bit 1 of its control byte is 1 and its `tx_pend_i` bit is 1.
- R4: The receive source of a channel is active when bits 4:3 of its control byte are 01 or 10 and its `rx_pend_i` bit is 1. The values 00 and 11 disable it.
- R5: The break source of a channel is active when bit 7 of its byte in `wr_ext_i` and bit 7 of its byte in `rd_line_i` are both 1.
- R6: `irq_o` is 1 exactly when at least one channel has its master enable set and at least one active source. A request from either channel alone is enough.
- R7: `pend_stat_o` places the flags as follows: bit 5 is channel A receive pending, bit 4 is channel A transmit pending, bit 2 is channel B receive pending and bit 1 is channel B transmit pending. Bits 7, 6, 3 and 0 read 0.
- R8: `pend_stat_o` follows the raw pending flags and ignores every enable field and the break inputs.
- R9: Both outputs are registered. A change on an input shows up on the outputs after the next rising edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cfg_i | input | 2*CFG_W | Interrupt control bytes; [7:0] channel A, [15:8] channel B |
| wr_ext_i | input | 2*CFG_W | Extended control bytes; bit 7 of each enables break |
| rd_line_i | input | 2*CFG_W | Line status bytes; bit 7 of each is the break flag |
| tx_pend_i | input | 2 | Transmit pending flags; bit 0 channel A, bit 1 channel B |
| rx_pend_i | input | 2 | Receive pending flags; bit 0 channel A, bit 1 channel B |
| irq_o | output | 1 | Shared interrupt request, registered |
| pend_stat_o | output | STAT_W | Combined pending-status byte, registered |

## Verification
The assertions take for granted that the inputs are stable around each rising edge and that they come from the channel registers' own flops. Under that assumption, every qualified request is visible on the very next edge. The properties relate the inputs sampled on one edge to the outputs one edge later. They also take for granted that every input is driven to a known 0 or 1 from the first edge onward. The bench meets these assumptions: it changes inputs only at falling edges, drives every input to a defined value before reset is released, and samples the outputs at the falling edge after the capturing rising edge.

// File: rtl/dim_pkg.sv
package dim_pkg;
  localparam int NCH  = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;

  // receive interrupt mode decode: only the two single-bit codes are live
  function automatic logic rx_mode_live(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction
endpackage

// File: rtl/dim_src_qual.sv
module dim_src_qual #(
  parameter int CFG_W    = 8,
  parameter int EN_BIT   = 0,
  parameter int TXE_BIT  = 1,
  parameter int RXM_LO   = 3,
  parameter int BRKE_BIT = 7,
  parameter int BRKF_BIT = 7
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [CFG_W-1:0] ext,
  input  logic [CFG_W-1:0] line,
  input  logic             txp,
  input  logic             rxp,
  output logic             req
);
  import dim_pkg::*;

  logic tx_act, rx_act, brk_act;
  logic unused_bits;

  always_comb begin
    tx_act  = cfg[TXE_BIT] & txp;
    rx_act  = rx_mode_live(cfg[RXM_LO +: 2]) & rxp;
    brk_act = ext[BRKE_BIT] & line[BRKF_BIT];
    req     = cfg[EN_BIT] & (tx_act | rx_act | brk_act);
  end

  assign unused_bits = ^{cfg, ext, line};
endmodule

// File: rtl/dim_stat_pack.sv
module dim_stat_pack #(
  parameter int STAT_W = 8,
  parameter int A_RX   = 5,
  parameter int A_TX   = 4,
  parameter int B_RX   = 2,
  parameter int B_TX   = 1
) (
  input  logic [dim_pkg::NCH-1:0] txp,
  input  logic [dim_pkg::NCH-1:0] rxp,
  output logic [STAT_W-1:0]       stat
);
  import dim_pkg::*;

  function automatic int rx_pos(input int c);
    return (c == CH_A) ? A_RX : B_RX;
  endfunction

  function automatic int tx_pos(input int c);
    return (c == CH_A) ? A_TX : B_TX;
  endfunction

  always_comb begin
    stat = '0;
    for (int c = 0; c < NCH; c++) begin
      stat[rx_pos(c)] = rxp[c];
      stat[tx_pos(c)] = txp[c];
    end
  end
endmodule

// File: rtl/dim_out_reg.sv
module dim_out_reg #(
  parameter int STAT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [dim_pkg::NCH-1:0] req,
  input  logic [STAT_W-1:0]       stat_d,
  output logic                    irq_q,
  output logic [STAT_W-1:0]       stat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      irq_q  <= |req;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/dual_irq_merge.sv
module dual_irq_merge #(
  parameter int CFG_W  = 8,
  parameter int STAT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*CFG_W-1:0]  wr_cfg_i,
  input  logic [2*CFG_W-1:0]  wr_ext_i,
  input  logic [2*CFG_W-1:0]  rd_line_i,
  input  logic [1:0]          tx_pend_i,
  input  logic [1:0]          rx_pend_i,
  output logic                irq_o,
  output logic [STAT_W-1:0]   pend_stat_o
);
  import dim_pkg::*;

  logic [NCH-1:0]    ch_req;
  logic [STAT_W-1:0] stat_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dim_src_qual #(.CFG_W(CFG_W)) u_qual (
      .cfg  (wr_cfg_i[c*CFG_W +: CFG_W]),
      .ext  (wr_ext_i[c*CFG_W +: CFG_W]),
      .line (rd_line_i[c*CFG_W +: CFG_W]),
      .txp  (tx_pend_i[c]),
      .rxp  (rx_pend_i[c]),
      .req  (ch_req[c])
    );
  end

  dim_stat_pack #(.STAT_W(STAT_W)) u_pack (
    .txp  (tx_pend_i),
    .rxp  (rx_pend_i),
    .stat (stat_d)
  );

  dim_out_reg #(.STAT_W(STAT_W)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .req    (ch_req),
    .stat_d (stat_d),
    .irq_q  (irq_o),
    .stat_q (pend_stat_o)
  );
endmodule

// File: rtl/dim_chk.sv
module dim_chk #(
  parameter int CFG_W  = 8,
  parameter int STAT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [2*CFG_W-1:0] wr_cfg_i,
  input logic [2*CFG_W-1:0] wr_ext_i,
  input logic [2*CFG_W-1:0] rd_line_i,
  input logic [1:0]         tx_pend_i,
  input logic [1:0]         rx_pend_i,
  input logic               irq_o,
  input logic [STAT_W-1:0]  pend_stat_o
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && pend_stat_o == '0));

  p_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_cfg_i[0] && !wr_cfg_i[CFG_W]) |=> !irq_o);

  p_tx_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg_i[0] && wr_cfg_i[1] && tx_pend_i[0]) |=> irq_o);

  p_rx_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg_i[CFG_W] && wr_cfg_i[CFG_W+4 -: 2] == 2'b10 && rx_pend_i[1]) |=> irq_o);

  p_brk_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg_i[CFG_W] && wr_ext_i[2*CFG_W-1] && rd_line_i[2*CFG_W-1]) |=> irq_o);

  p_stat_b_r7: assert property (@(posedge clk) disable iff (rst)
    tx_pend_i[1] |=> pend_stat_o[1]);

  p_stat_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_pend_i == 2'b00 && rx_pend_i == 2'b00) |=> pend_stat_o == '0);
endmodule

bind dual_irq_merge dim_chk #(.CFG_W(CFG_W), .STAT_W(STAT_W)) u_dim_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_cfg_i    (wr_cfg_i),
  .wr_ext_i    (wr_ext_i),
  .rd_line_i   (rd_line_i),
  .tx_pend_i   (tx_pend_i),
  .rx_pend_i   (rx_pend_i),
  .irq_o       (irq_o),
  .pend_stat_o (pend_stat_o)
);

// File: tb/dual_irq_merge_bench.sv
module dual_irq_merge_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] wr_cfg_i  = '0;
  logic [15:0] wr_ext_i  = '0;
  logic [15:0] rd_line_i = '0;
  logic [1:0]  tx_pend_i = '0;
  logic [1:0]  rx_pend_i = '0;
  logic        irq_o;
  logic [7:0]  pend_stat_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_irq_merge u_dual_irq_merge (
    .clk(clk), .rst(rst), .wr_cfg_i(wr_cfg_i), .wr_ext_i(wr_ext_i),
    .rd_line_i(rd_line_i), .tx_pend_i(tx_pend_i), .rx_pend_i(rx_pend_i),
    .irq_o(irq_o), .pend_stat_o(pend_stat_o)
  );

  task automatic drive(input logic [7:0] ca, input logic [7:0] cb,
                       input logic [7:0] ea, input logic [7:0] eb,
                       input logic [7:0] la, input logic [7:0] lb,
                       input logic [1:0] tp, input logic [1:0] rp);
    wr_cfg_i  = {cb, ca};
    wr_ext_i  = {eb, ea};
    rd_line_i = {lb, la};
    tx_pend_i = tp;
    rx_pend_i = rp;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    checks++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL %s irq_o actual=%b expected=%b", req, irq_o, exp);
    end
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    checks++;
    if (pend_stat_o !== exp) begin
      fails++;
      $display("FAIL %s pend_stat_o actual=%h expected=%h", req, pend_stat_o, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(8'hFF, 8'hFF, 8'h80, 8'h80, 8'h80, 8'h80, 2'b11, 2'b11);
    step();
    chk_irq("R1", 1'b0);
    chk_stat("R1", 8'h00);
    drive(0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    step();
    rst = 1'b0;
    step();
  endtask

  task automatic t_tx();
    drive(8'h03, 8'h00, 0, 0, 0, 0, 2'b01, 2'b00);
    step();
    chk_irq("R3", 1'b1);
    chk_stat("R7", 8'h10);
    drive(8'h01, 8'h00, 0, 0, 0, 0, 2'b01, 2'b00);
    step();
    chk_irq("R3", 1'b0);
    drive(8'h00, 8'h03, 0, 0, 0, 0, 2'b10, 2'b00);
    step();
    chk_irq("R3", 1'b1);
    chk_stat("R7", 8'h02);
  endtask

  task automatic t_rx_modes();
    for (int m = 0; m < 4; m++) begin
      drive(8'h00, 8'h01 | 8'(m << 3), 0, 0, 0, 0, 2'b00, 2'b10);
      step();
      chk_irq("R4", (m == 1) || (m == 2));
      chk_stat("R7", 8'h04);
    end
    drive(8'h09, 8'h00, 0, 0, 0, 0, 2'b00, 2'b01);
    step();
    chk_irq("R4", 1'b1);
    chk_stat("R7", 8'h20);
  endtask

  task automatic t_brk();
    drive(8'h01, 8'h00, 8'h80, 0, 8'h80, 0, 2'b00, 2'b00);
    step();
    chk_irq("R5", 1'b1);
    chk_stat("R8", 8'h00);
    drive(8'h01, 8'h00, 8'h80, 0, 8'h7F, 0, 2'b00, 2'b00);
    step();
    chk_irq("R5", 1'b0);
    drive(8'h01, 8'h00, 8'h7F, 0, 8'h80, 0, 2'b00, 2'b00);
    step();
    chk_irq("R5", 1'b0);
    drive(8'h00, 8'h01, 0, 8'h80, 0, 8'h80, 2'b00, 2'b00);
    step();
    chk_irq("R5", 1'b1);
  endtask

  task automatic t_mask();
    drive(8'hFE, 8'hFE, 8'h80, 8'h80, 8'h80, 8'h80, 2'b11, 2'b11);
    step();
    chk_irq("R2", 1'b0);
    chk_stat("R8", 8'h36);
    drive(8'hFE, 8'hFF, 8'h80, 8'h80, 8'h80, 8'h80, 2'b11, 2'b11);
    step();
    chk_irq("R2", 1'b1);
  endtask

  task automatic t_or();
    drive(8'h03, 8'h00, 0, 0, 0, 0, 2'b11, 2'b00);
    step();
    chk_irq("R6", 1'b1);
    drive(8'h00, 8'h11, 0, 0, 0, 0, 2'b00, 2'b11);
    step();
    chk_irq("R6", 1'b1);
    chk_stat("R7", 8'h24);
    drive(8'h03, 8'h11, 0, 0, 0, 0, 2'b11, 2'b11);
    step();
    chk_irq("R6", 1'b1);
    chk_stat("R7", 8'h36);
    drive(8'h01, 8'h19, 0, 0, 0, 0, 2'b11, 2'b11);
    step();
    chk_irq("R6", 1'b0);
  endtask

  task automatic t_latency();
    drive(0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    step();
    drive(8'h03, 8'h00, 0, 0, 0, 0, 2'b01, 2'b00);
    #1;
    chk_irq("R9", 1'b0);
    chk_stat("R9", 8'h00);
    step();
    chk_irq("R9", 1'b1);
    chk_stat("R9", 8'h10);
    drive(0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    #1;
    chk_irq("R9", 1'b1);
    step();
    chk_irq("R9", 1'b0);
    chk_stat("R8", 8'h00);
  endtask

  task automatic t_midreset();
    drive(8'h03, 8'h03, 0, 0, 0, 0, 2'b11, 2'b11);
    step();
    chk_irq("R6", 1'b1);
    rst = 1'b1;
    step();
    chk_irq("R1", 1'b0);
    chk_stat("R1", 8'h00);
    rst = 1'b0;
    step();
    chk_irq("R1", 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx_modes();
    t_brk();
    t_mask();
    t_or();
    t_latency();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule